// File: doc/BRIEF.md
# Program Counter Sequencer

This block keeps the fetch address of a simple single-issue processor and decides, on every rising clock edge, where the next fetch comes from. It has three candidates. The first is the sequential address, which is the current address plus four. The second is a conditional branch target: a signed word offset, taken from the low half of the instruction, added to the sequential address. The third is an absolute jump target placed inside the current 256 MiB region.

The block takes control bits that have already been decoded. These are a branch request, a jump request and the zero flag from the ALU compare. From the raw instruction it uses only the displacement and index fields. Its two outputs are the registered fetch address and the incremented address, so a later link or return path can reuse the increment.

Top module: `pcseq_unit`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising edge, `pc_q` becomes 0x00000000 after that edge, whatever the other inputs are.
- R2: When `jmp_en` is low and the branch is not taken, `pc_q` advances by exactly 4 at each rising edge, modulo 2^32.
- R3: `pc_plus4` always equals `pc_q` + 4, modulo 2^32.
- R4: When `br_en` and `alu_zero` are both high and `jmp_en` is low, the next `pc_q` is `pc_plus4` + (sign-extended `instr[15:0]` shifted left by 2).
- R5: A branch is not taken when `br_en` is low, or when `alu_zero` is low. In either case the next `pc_q` is the sequential address.
- R6: A displacement with bit 15 set counts backward. For example, 0xFFFE moves the target 8 bytes below `pc_plus4`, and this can wrap below address 0.
- R7: When `jmp_en` is high, the next `pc_q` is {`pc_q[31:28]`, `instr[25:0]`, 2'b00}. `instr[31:26]` has no effect.
- R8: When `jmp_en` and a taken branch occur in the same cycle, the jump target wins.
- R9: `pc_q[1:0]` is 00 in every cycle after reset.
- R10: The sequential step from 0xFFFFFFFC wraps to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Current instruction word |
| br_en | input | 1 | Decoded conditional-branch request |
| jmp_en | input | 1 | Decoded jump request |
| alu_zero | input | 1 | ALU result-is-zero flag from the operand compare |
| pc_q | output | 32 | Current fetch address |
| pc_plus4 | output | 32 | Fetch address plus four |

## Verification
The bench targets these corner cases:
- Negative displacements that step backward past address 0. A design that zero-extends instead of sign-extending lands far ahead of the branch.
- Displacements added to the current address rather than to the incremented one. Such a design comes out 4 bytes short on every taken branch.
- A jump issued together with a taken branch. A design with the wrong priority follows the branch target.
- Jumps from different regions, with nonzero opcode bits in the instruction. A design that drops or mixes up the region bits leaves the region after a jump, and one that lets the opcode bits through corrupts the target.
- The sequential step across the region boundary and the wrap from the top of memory. A design with a short adder or a misplaced carry gets these steps wrong.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   // byte offset bits dropped by word addressing
   localparam int unsigned ALIGN_W = 2;

   typedef enum logic [1:0] {
      SRC_SEQ = 2'd0,
      SRC_BR  = 2'd1,
      SRC_JMP = 2'd2
   } next_src_e;
endpackage

// File: rtl/pcseq_target_calc.sv
module pcseq_target_calc
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DISP_W = 16,
   parameter int unsigned IDX_W  = 26
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [IDX_W-1:0]  field,
   output logic [ADDR_W-1:0] seq_addr,
   output logic [ADDR_W-1:0] br_addr,
   output logic [ADDR_W-1:0] jmp_addr
);
   localparam int unsigned REGION_W = ADDR_W - IDX_W - ALIGN_W;
   localparam int unsigned EXT_W    = ADDR_W - DISP_W;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] disp_bytes;

   if (IDX_W < DISP_W) begin : g_bad_fields
      $error("pcseq_target_calc: index field narrower than displacement");
   end

   always_comb begin
      seq_addr   = pc + STEP;
      disp_ext   = {{EXT_W{field[DISP_W-1]}}, field[DISP_W-1:0]};
      disp_bytes = disp_ext << ALIGN_W;
      br_addr    = seq_addr + disp_bytes;
      jmp_addr   = {pc[ADDR_W-1 -: REGION_W], field, {ALIGN_W{1'b0}}};
   end
endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned MUX_STYLE = 0   // 0: priority chain, 1: one-hot AND-OR
) (
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic [ADDR_W-1:0] jmp_addr,
   input  logic              br_en,
   input  logic              jmp_en,
   input  logic              alu_zero,
   output logic [ADDR_W-1:0] next_addr
);
   next_src_e src;
   logic      br_taken;

   always_comb begin
      br_taken = br_en & alu_zero;
      if (jmp_en)        src = SRC_JMP;
      else if (br_taken) src = SRC_BR;
      else               src = SRC_SEQ;
   end

   if (MUX_STYLE == 0) begin : g_prio
      always_comb begin
         unique case (src)
            SRC_JMP: next_addr = jmp_addr;
            SRC_BR:  next_addr = br_addr;
            default: next_addr = seq_addr;
         endcase
      end
   end else if (MUX_STYLE == 1) begin : g_andor
      logic [2:0] hot;
      always_comb begin
         hot[0] = (src == SRC_SEQ);
         hot[1] = (src == SRC_BR);
         hot[2] = (src == SRC_JMP);
         next_addr = ({ADDR_W{hot[0]}} & seq_addr)
                   | ({ADDR_W{hot[1]}} & br_addr)
                   | ({ADDR_W{hot[2]}} & jmp_addr);
      end
   end else begin : g_bad_style
      $error("pcseq_select: MUX_STYLE must be 0 or 1");
   end
endmodule

// File: rtl/pcseq_reg.sv
module pcseq_reg #(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RESET_VAL;
      else     q <= d;
   end
endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned INSTR_W   = 32,
   parameter int unsigned DISP_W    = 16,
   parameter int unsigned IDX_W     = 26,
   parameter int unsigned MUX_STYLE = 0,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic               br_en,
   input  logic               jmp_en,
   input  logic               alu_zero,
   output logic [ADDR_W-1:0]  pc_q,
   output logic [ADDR_W-1:0]  pc_plus4
);
   if (IDX_W + ALIGN_W >= ADDR_W) begin : g_bad_region
      $error("pcseq_unit: no upper region bits left for jumps");
   end
   if (IDX_W > INSTR_W) begin : g_bad_instr
      $error("pcseq_unit: index field wider than instruction");
   end
   if (RESET_PC[ALIGN_W-1:0] != '0) begin : g_bad_reset
      $error("pcseq_unit: reset address not word aligned");
   end

   logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr, next_addr;

   pcseq_target_calc #(
      .ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W)
   ) u_calc (
      .pc       (pc_q),
      .field    (instr[IDX_W-1:0]),
      .seq_addr (seq_addr),
      .br_addr  (br_addr),
      .jmp_addr (jmp_addr)
   );

   pcseq_select #(
      .ADDR_W(ADDR_W), .MUX_STYLE(MUX_STYLE)
   ) u_sel (
      .seq_addr  (seq_addr),
      .br_addr   (br_addr),
      .jmp_addr  (jmp_addr),
      .br_en     (br_en),
      .jmp_en    (jmp_en),
      .alu_zero  (alu_zero),
      .next_addr (next_addr)
   );

   pcseq_reg #(
      .ADDR_W(ADDR_W), .RESET_VAL(RESET_PC)
   ) u_pc (
      .clk (clk),
      .rst (rst),
      .d   (next_addr),
      .q   (pc_q)
   );

   assign pc_plus4 = seq_addr;
endmodule

// File: rtl/pcseq_unit_chk.sv
module pcseq_unit_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INSTR_W = 32
) (
   input logic               clk,
   input logic               rst,
   input logic [INSTR_W-1:0] instr,
   input logic               br_en,
   input logic               jmp_en,
   input logic               alu_zero,
   input logic [ADDR_W-1:0]  pc_q,
   input logic [ADDR_W-1:0]  pc_plus4
);
   // R2
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!jmp_en && !(br_en && alu_zero)) |=> (pc_q == $past(pc_q) + 32'd4));

   // R3
   plus4_chk: assert property (@(posedge clk) disable iff (rst)
      pc_plus4 == pc_q + 32'd4);

   // R4
   br_target_chk: assert property (@(posedge clk) disable iff (rst)
      (!jmp_en && br_en && alu_zero) |=>
      (pc_q == $past(pc_plus4) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

   // R7
   jmp_target_chk: assert property (@(posedge clk) disable iff (rst)
      jmp_en |=> (pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00}));

   // R9
   align_chk: assert property (@(posedge clk) disable iff (rst)
      pc_q[1:0] == 2'b00);
endmodule

bind pcseq_unit pcseq_unit_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
   .clk(clk), .rst(rst), .instr(instr), .br_en(br_en), .jmp_en(jmp_en),
   .alu_zero(alu_zero), .pc_q(pc_q), .pc_plus4(pc_plus4)
);

// File: tb/tb_pcseq_unit.sv
module tb_pcseq_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic        br_en = 1'b0, jmp_en = 1'b0, alu_zero = 1'b0;
   logic [31:0] pc_q, pc_plus4;

   int n_checks = 0;
   int n_errors = 0;
   logic [31:0] model_pc = '0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   pcseq_unit dut (
      .clk(clk), .rst(rst), .instr(instr), .br_en(br_en), .jmp_en(jmp_en),
      .alu_zero(alu_zero), .pc_q(pc_q), .pc_plus4(pc_plus4)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // driver: set inputs at falling edge, push expected post-edge PC
   task automatic step(input logic r, input logic [31:0] ins, input logic b,
                       input logic j, input logic z, input string tag);
      logic [31:0] nxt, seq, disp;
      @(negedge clk);
      rst = r; instr = ins; br_en = b; jmp_en = j; alu_zero = z;
      seq  = model_pc + 32'd4;
      disp = {{14{ins[15]}}, ins[15:0], 2'b00};
      if (r)           nxt = 32'h0;
      else if (j)      nxt = {model_pc[31:28], ins[25:0], 2'b00};
      else if (b && z) nxt = seq + disp;
      else             nxt = seq;
      model_pc = nxt;
      exp_q.push_back(nxt);
      tag_q.push_back(tag);
   endtask

   // monitor: sample after each rising edge, compare against scoreboard
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if (pc_q !== e) begin
            n_errors++;
            $display("FAIL %s pc_q actual=%h expected=%h", t, pc_q, e);
         end
         n_checks++;
         if (pc_plus4 !== e + 32'd4) begin
            n_errors++;
            $display("FAIL R3 pc_plus4 actual=%h expected=%h", pc_plus4, e + 32'd4);
         end
         n_checks++;
         if (pc_q[1:0] !== 2'b00) begin
            n_errors++;
            $display("FAIL R9 pc_q[1:0] actual=%b expected=00", pc_q[1:0]);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 2000);
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
   end

   initial begin
      step(1, 32'hFFFF_FFFF, 1, 1, 1, "R1 reset");
      step(1, 32'h0,         0, 0, 0, "R1 reset hold");
      step(0, 32'h0,         0, 0, 0, "R2 seq");            // 4
      step(0, 32'h1234_0003, 0, 0, 1, "R2 seq");            // 8
      step(0, 32'h0,         0, 0, 0, "R2 seq");            // 0xC
      step(0, 32'h1000_0003, 1, 0, 1, "R4 branch fwd");     // 0x1C
      step(0, 32'h1000_0003, 1, 0, 0, "R5 zero low");       // 0x20
      step(0, 32'h1000_0040, 0, 0, 1, "R5 br_en low");      // 0x24
      step(0, 32'h1000_FFFE, 1, 0, 1, "R6 branch back");    // 0x20
      step(0, 32'h0800_0100, 0, 1, 0, "R7 jump");           // 0x400
      step(0, 32'hFFFF_FFFF, 1, 1, 1, "R8 jump over br");   // 0x0FFFFFFC
      step(0, 32'h0,         0, 0, 0, "R2 region cross");   // 0x10000000
      step(0, 32'hFC00_0005, 0, 1, 0, "R7 region kept");    // 0x10000014
      step(1, 32'h0,         0, 1, 0, "R1 mid reset");      // 0
      step(0, 32'h1000_FFFE, 1, 0, 1, "R6 wrap below 0");   // 0xFFFFFFFC
      step(0, 32'h0,         0, 0, 0, "R10 wrap top");      // 0
      step(0, 32'h1000_FFFE, 1, 0, 1, "R6 wrap below 0");   // 0xFFFFFFFC
      step(0, 32'h0000_0001, 1, 1, 0, "R7 top region");     // 0xF0000004
      step(0, 32'h1000_8000, 1, 0, 1, "R6 max back");       // 0xF0000008-0x20000
      @(negedge clk);
      br_en = 0; jmp_en = 0;
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule